// File: doc/BRIEF.md
# Configurable-Format Serial Receiver

This block recovers asynchronous serial characters from a single receive line. It runs from a baud tick enable that pulses sixteen times per bit period. A 6-bit format word selects the character shape at run time: 5 to 8 data bits, an optional parity bit with odd, even or fixed-value checking, and a short or long stop period. The transmitter on the same link uses the same format word.

A falling edge on the line opens a frame. The start bit is confirmed half a bit later, and every later bit is sampled at the middle of its period, least significant bit first. When the first stop bit has been sampled, the block gives a single-cycle valid pulse. The pulse carries the data, right-justified and zero-extended to 8 bits, together with a parity-error flag and a framing-error flag. The data is delivered even when a flag is raised.

The format word is captured when a frame opens, so software may change it while a character is in flight. The change applies to the following frame.

Top module: `uart_fmt_rx`

## Requirements
- R1: After reset, valid_o, par_err_o and frm_err_o are 0 and data_o is 0.
- R2: Format bits [1:0] set the data length as 00=5, 01=6, 10=7 and 11=8 bits. Data is received least significant bit first and placed in data_o[n-1:0]. The bits of data_o above the data length are 0.
- R3: With format bit 3 = 0, no parity bit is expected. The bit that follows the data is taken as the stop bit, and par_err_o stays 0.
- R4: With format bit 3 = 1 and bit 5 = 0, parity is checked as odd when bit 4 = 0 and as even when bit 4 = 1. par_err_o is set when the data bits and the parity bit together do not have the selected parity.
- R5: With format bits 3 and 5 both 1, the received parity bit must be 1 when bit 4 = 0 and 0 when bit 4 = 1. Any other value sets par_err_o.
- R6: A low level that is high again when re-sampled half a bit after the falling edge is treated as a false start. No character is reported for it.
- R7: If the first stop bit is sampled low, frm_err_o is set with that character, and the data is still delivered.
- R8: valid_o is high for exactly one clock per character. par_err_o and frm_err_o can be high only during that clock.
- R9: With format bit 2 = 1, the line is ignored after the first stop sample for the rest of the long stop period: 16 ticks for lengths of 6 to 8 bits and 8 ticks for 5 bits. A low level inside that window does not open a frame.
- R10: The format word is captured when a frame opens. A change to format_i during a frame does not affect that frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Baud tick enable, sixteen pulses per bit |
| rx_i | input | 1 | Serial receive line, idle high |
| format_i | input | 6 | Format word: [1:0] length, [2] long stop, [3] parity enable, [4] parity type, [5] forced parity |
| valid_o | output | 1 | One-clock pulse when a character is complete |
| data_o | output | 8 | Received data, right-justified and zero-extended |
| par_err_o | output | 1 | Parity mismatch for the reported character |
| frm_err_o | output | 1 | First stop bit sampled low |

## Verification
The bench builds the block with its default parameters: sixteen ticks per bit, an 8-bit data register and a two-stage line synchronizer. It drives one tick every fourth clock, so one bit lasts 64 clocks. This rate keeps every frame short enough to cover all four data lengths, every parity mode with correct and inverted parity bits, and both stop lengths in one run. The same timing allows a low glitch to be placed inside the long-stop window and mid-frame format changes to be made at known offsets from the start edge.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    localparam int FMT_W      = 6;
    localparam int FMT_LEN    = 0;
    localparam int FMT_LSTOP  = 2;
    localparam int FMT_PEN    = 3;
    localparam int FMT_PTYPE  = 4;
    localparam int FMT_PFORCE = 5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP,
        ST_GUARD
    } rx_state_e;

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], d_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= chain_d;
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/uart_rx_fmt_dec.sv
module uart_rx_fmt_dec
    import uart_rx_pkg::*;
#(
    parameter int OVERSAMPLE = 16,
    parameter int IDX_W      = 3,
    parameter int CNT_W      = 5
) (
    input  logic [FMT_W-1:0] fmt_i,
    output logic [IDX_W-1:0] last_idx_o,
    output logic             par_en_o,
    output logic [CNT_W-1:0] guard_len_o
);
    logic [1:0] len;
    logic       long_stop;

    always_comb begin
        len        = fmt_i[FMT_LEN+1:FMT_LEN];
        long_stop  = fmt_i[FMT_LSTOP];
        last_idx_o = IDX_W'(4) + IDX_W'(len);
        par_en_o   = fmt_i[FMT_PEN];
        if (!long_stop)
            guard_len_o = '0;
        else if (len == 2'b00)
            guard_len_o = CNT_W'(OVERSAMPLE / 2);
        else
            guard_len_o = CNT_W'(OVERSAMPLE);
    end
endmodule

// File: rtl/uart_rx_parity.sv
module uart_rx_parity #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] data_i,
    input  logic              even_i,
    input  logic              forced_i,
    output logic              exp_bit_o
);
    logic ones_odd;

    always_comb begin
        ones_odd = ^data_i;
        if (forced_i)
            exp_bit_o = ~even_i;
        else if (even_i)
            exp_bit_o = ones_odd;
        else
            exp_bit_o = ~ones_odd;
    end
endmodule

// File: rtl/uart_fmt_rx.sv
module uart_fmt_rx
    import uart_rx_pkg::*;
#(
    parameter int OVERSAMPLE  = 16,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              rx_i,
    input  logic [5:0]        format_i,
    output logic              valid_o,
    output logic [DATA_W-1:0] data_o,
    output logic              par_err_o,
    output logic              frm_err_o
);
    localparam int IDX_W = $clog2(DATA_W);
    localparam int CNT_W = $clog2(OVERSAMPLE) + 1;
    localparam int HALF  = OVERSAMPLE / 2;

    typedef struct packed {
        rx_state_e         state;
        logic [CNT_W-1:0]  cnt;
        logic [IDX_W-1:0]  idx;
        logic [FMT_W-1:0]  fmt;
        logic [DATA_W-1:0] data;
        logic              pbit;
        logic              valid;
        logic              perr;
        logic              ferr;
    } rx_regs_t;

    rx_regs_t st_q, st_d;

    logic             rx_s;
    logic [IDX_W-1:0] last_idx;
    logic             par_en;
    logic [CNT_W-1:0] guard_len;
    logic             exp_par;
    logic [FMT_W-1:0] cur_fmt;
    logic             bit_end;

    uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (rx_i),
        .q_o   (rx_s)
    );

    uart_rx_fmt_dec #(
        .OVERSAMPLE (OVERSAMPLE),
        .IDX_W      (IDX_W),
        .CNT_W      (CNT_W)
    ) u_dec (
        .fmt_i       (st_q.fmt),
        .last_idx_o  (last_idx),
        .par_en_o    (par_en),
        .guard_len_o (guard_len)
    );

    uart_rx_parity #(.DATA_W(DATA_W)) u_par (
        .data_i    (st_q.data),
        .even_i    (st_q.fmt[FMT_PTYPE]),
        .forced_i  (st_q.fmt[FMT_PFORCE]),
        .exp_bit_o (exp_par)
    );

    assign cur_fmt = st_q.fmt;
    assign bit_end = (st_q.cnt == CNT_W'(OVERSAMPLE - 1));

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        st_d.perr  = 1'b0;
        st_d.ferr  = 1'b0;
        if (tick_i) begin
            unique case (st_q.state)
                ST_IDLE: begin
                    if (!rx_s) begin
                        st_d.state = ST_START;
                        st_d.cnt   = '0;
                        st_d.fmt   = format_i;
                        st_d.data  = '0;
                        st_d.pbit  = 1'b0;
                    end
                end
                ST_START: begin
                    if (st_q.cnt == CNT_W'(HALF - 1)) begin
                        st_d.cnt   = '0;
                        st_d.idx   = '0;
                        st_d.state = rx_s ? ST_IDLE : ST_DATA;
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
                ST_DATA: begin
                    if (bit_end) begin
                        st_d.cnt              = '0;
                        st_d.data[st_q.idx]   = rx_s;
                        if (st_q.idx == last_idx)
                            st_d.state = par_en ? ST_PAR : ST_STOP;
                        else
                            st_d.idx = st_q.idx + 1'b1;
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
                ST_PAR: begin
                    if (bit_end) begin
                        st_d.cnt   = '0;
                        st_d.pbit  = rx_s;
                        st_d.state = ST_STOP;
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
                ST_STOP: begin
                    if (bit_end) begin
                        st_d.cnt   = '0;
                        st_d.valid = 1'b1;
                        st_d.perr  = par_en && (st_q.pbit != exp_par);
                        st_d.ferr  = !rx_s;
                        st_d.state = (guard_len != '0) ? ST_GUARD : ST_IDLE;
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
                ST_GUARD: begin
                    if (st_q.cnt == guard_len - 1'b1) begin
                        st_d.cnt   = '0;
                        st_d.state = ST_IDLE;
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
                default: st_d.state = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.state <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign valid_o   = st_q.valid;
    assign data_o    = st_q.data;
    assign par_err_o = st_q.perr;
    assign frm_err_o = st_q.ferr;
endmodule

// File: rtl/uart_fmt_rx_chk.sv
module uart_fmt_rx_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              valid_o,
    input logic [DATA_W-1:0] data_o,
    input logic              par_err_o,
    input logic              frm_err_o,
    input logic [5:0]        fmt_q
);
    p_valid_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    p_flags_with_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (par_err_o || frm_err_o) |-> valid_o);

    p_short_word_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && fmt_q[1:0] == 2'b00) |-> (data_o[DATA_W-1:5] == '0));

    p_no_parity_no_perr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !fmt_q[3]) |-> !par_err_o);
endmodule

bind uart_fmt_rx uart_fmt_rx_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .valid_o   (valid_o),
    .data_o    (data_o),
    .par_err_o (par_err_o),
    .frm_err_o (frm_err_o),
    .fmt_q     (cur_fmt)
);

// File: tb/tb_uart_fmt_rx.sv
`timescale 1ns/1ps
module tb_uart_fmt_rx;
    localparam int BITCLK = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx = 1'b1;
    logic [5:0] fmt = 6'b000011;
    logic       valid;
    logic [7:0] data;
    logic       perr, ferr;
    logic [1:0] tdiv = 2'd0;
    logic       tick;

    int checks = 0;
    int errors = 0;
    int pushed = 0;
    int seen = 0;
    logic [9:0] exp_q[$];
    logic prev_valid = 1'b0;

    always #4 clk = ~clk;

    always_ff @(posedge clk) tdiv <= tdiv + 2'd1;
    assign tick = (tdiv == 2'd3);

    uart_fmt_rx dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick),
        .rx_i      (rx),
        .format_i  (fmt),
        .valid_o   (valid),
        .data_o    (data),
        .par_err_o (perr),
        .frm_err_o (ferr)
    );

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // monitor: compares each reported character against the scoreboard (R2-R5, R7, R8)
    always @(negedge clk) begin
        if (rst_n) begin
            if (valid && prev_valid) chk("R8 valid width", 32'd2, 32'd1);
            if ((perr || ferr) && !valid) chk("R8 flags outside valid", {perr, ferr}, 32'd0);
            if (valid) begin
                seen++;
                if (exp_q.size() == 0) begin
                    chk("R6/R9 unexpected character", {22'd0, data, perr, ferr}, 32'h0);
                end else begin
                    logic [9:0] e;
                    e = exp_q.pop_front();
                    chk("R2 data", data, e[9:2]);
                    chk("R4/R5 parity flag", perr, e[1]);
                    chk("R7 framing flag", ferr, e[0]);
                end
            end
            prev_valid <= valid;
        end
    end

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] d, input logic [5:0] f, input bit flip,
                        input bit bad_stop, input bit mid_change, input logic [5:0] f2);
        int n;
        logic [7:0] dm;
        logic p;
        n  = 5 + int'(f[1:0]);
        dm = d & (8'hFF >> (3 - f[1:0]));
        if (f[5])      p = ~f[4];
        else if (f[4]) p = ^dm;
        else           p = ~^dm;
        if (flip) p = ~p;
        exp_q.push_back({dm, flip & f[3], bad_stop});
        pushed++;
        @(negedge clk);
        fmt = f;
        rx  = 1'b0;
        if (mid_change) begin
            waitc(20);
            fmt = f2;
            waitc(BITCLK - 20);
        end else begin
            waitc(BITCLK);
        end
        for (int i = 0; i < n; i++) begin
            rx = dm[i];
            waitc(BITCLK);
        end
        if (f[3]) begin
            rx = p;
            waitc(BITCLK);
        end
        if (bad_stop) begin
            rx = 1'b0;
            waitc(44);
            rx = 1'b1;
            waitc(BITCLK - 44);
        end else begin
            rx = 1'b1;
            waitc(BITCLK);
        end
        if (f[2]) waitc((f[1:0] == 2'b00) ? BITCLK / 2 : BITCLK);
        waitc(16);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        waitc(5);
        // R1: reset state
        chk("R1 valid", valid, 0);
        chk("R1 data", data, 0);
        chk("R1 flags", {perr, ferr}, 0);
        rst_n = 1'b1;
        waitc(20);

        // R2/R3: each length, no parity
        send(8'hA5, 6'b000011, 0, 0, 0, 0);
        send(8'hFF, 6'b000000, 0, 0, 0, 0);
        send(8'h2A, 6'b000001, 0, 0, 0, 0);
        send(8'hD5, 6'b000010, 0, 0, 0, 0);
        send(8'h13, 6'b000000, 1, 0, 0, 0);  // R3: flip ignored without parity

        // R4: odd and even parity
        send(8'h3C, 6'b001011, 0, 0, 0, 0);
        send(8'h3C, 6'b001011, 1, 0, 0, 0);
        send(8'h07, 6'b011011, 0, 0, 0, 0);
        send(8'h07, 6'b011011, 1, 0, 0, 0);
        send(8'h0B, 6'b011000, 1, 0, 0, 0);

        // R5: forced parity 1 and 0
        send(8'h81, 6'b101011, 0, 0, 0, 0);
        send(8'h81, 6'b101011, 1, 0, 0, 0);
        send(8'h6E, 6'b111010, 0, 0, 0, 0);
        send(8'h6E, 6'b111010, 1, 0, 0, 0);

        // R6: false start
        @(negedge clk);
        rx = 1'b0;
        waitc(20);
        rx = 1'b1;
        waitc(3 * BITCLK);
        chk("R6 false start count", seen, pushed);

        // R7: framing errors, data still delivered
        send(8'h5A, 6'b000111, 0, 1, 0, 0);
        send(8'hC3, 6'b001111, 1, 1, 0, 0);
        send(8'h66, 6'b000011, 0, 1, 0, 0);

        // R9: low level inside the long-stop window is ignored
        send(8'h99, 6'b000111, 0, 0, 0, 0);
        exp_q.push_back({8'hE4, 1'b0, 1'b0});
        pushed++;
        fmt = 6'b000111;
        rx = 1'b0; waitc(BITCLK);
        for (int i = 0; i < 8; i++) begin
            rx = 8'hE4 >> i;
            waitc(BITCLK);
        end
        rx = 1'b1; waitc(BITCLK);
        rx = 1'b0; waitc(48);
        rx = 1'b1; waitc(4 * BITCLK);
        chk("R9 guard count", seen, pushed);
        send(8'h1D, 6'b000100, 0, 0, 0, 0);

        // R10: format change mid-frame has no effect on that frame
        send(8'hB7, 6'b000011, 0, 0, 1, 6'b001000);
        send(8'h4C, 6'b011011, 0, 0, 1, 6'b000000);

        waitc(2 * BITCLK);
        chk("R2 all characters received", seen, pushed);
        chk("R8 scoreboard drained", exp_q.size(), 0);
        report();
    end
endmodule